// File: doc/BRIEF.md
# Serial Overhead Byte Inserter

This block feeds one path-overhead byte per frame into a transmit framer over a one-bit serial port. It runs on the framer's overhead clock, and it watches two framer outputs: a window enable and a frame marker. When both are high on the same rising edge, it takes a copy of the byte held on its parallel input. It then counts a programmed number of clock periods so that its first bit falls into the slot of the ninth overhead byte. After that it shifts the byte out, most significant bit first.

Each data bit is launched on a falling edge of the overhead clock, so the framer can sample it cleanly on the rising edge that follows. An insert-request line is high while the eight bits are on the line. On the parallel side the block shows a busy level and a one-cycle done pulse. After the eighth bit the block goes back to watching for the next window.

Top module: `ohi_top`

## Requirements
- R1: A synchronous active-low reset, sampled on the rising edge, returns the block to idle. After it, serOut, insertReq, busy and donePulse are all 0, including when the reset arrives in the middle of a transfer.
- R2: While idle, a transfer starts only on a rising edge where frmEnable and frmMark are both 1. Either signal high on its own has no effect.
- R3: The first data bit is driven on the falling edge that follows the rising edge lying WAIT_CYCLES clock periods after the trigger edge (default 64).
- R4: The eight bits leave most significant bit first, one on each of eight consecutive falling edges.
- R5: serOut changes only on falling clock edges and holds its value across every rising edge.
- R6: The byte sent is the value of byteIn at the trigger edge. Later changes to byteIn do not alter the byte in flight.
- R7: insertReq is 1 for exactly the eight clock periods in which data bits are on the line, and 0 at all other times.
- R8: serOut is 0 whenever insertReq is 0.
- R9: busy is 1 from the trigger edge up to the rising edge that samples the eighth bit. donePulse is 1 for exactly the one cycle that begins at that edge.
- R10: Once a transfer ends, the block watches the window signals again and can start again on the next rising edge. Window signals seen while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Framer overhead clock |
| rstN | input | 1 | Synchronous active-low reset |
| frmEnable | input | 1 | Insertion window enable from the framer |
| frmMark | input | 1 | Frame marker from the framer |
| byteIn | input | 8 | Parallel byte to insert |
| serOut | output | 1 | Serial data to the framer, launched on falling edges |
| insertReq | output | 1 | High while the byte's bits are on the line |
| busy | output | 1 | Transfer in progress (waiting or shifting) |
| donePulse | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The assertions assume that frmEnable, frmMark and byteIn change only away from the rising edge of the overhead clock. They also assume that rstN is held low through the first rising edge, so that the state is known before any property is evaluated. The stimulus drives every input one nanosecond after a rising edge and asserts reset from time zero. It also holds the window signals high during busy periods, including continuously across whole transfers, so that the ignore and immediate-restart paths are covered.

// File: rtl/ohi_pkg.sv
package ohi_pkg;

  // Width of the inserted overhead byte.
  localparam int DATA_W  = 8;
  localparam int IDX_W   = $clog2(DATA_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_SEND = 2'd2
  } ohiState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             capture;  // take byteIn into the hold register
    logic             launch;   // a data bit belongs on the line this period
    logic [IDX_W-1:0] bitSel;   // which bit of the hold register to launch
    logic             busy;     // a transfer is in progress
  } ohiStrobe_t;

endpackage

// File: rtl/ohi_ctrl.sv
module ohi_ctrl
  import ohi_pkg::*;
#(
  parameter int WAIT_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frmEnable,
  input  logic       frmMark,
  output ohiStrobe_t strb,
  output logic       busy,
  output logic       donePulse
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [IDX_W-1:0] TOP_BIT   = IDX_W'(DATA_W - 1);

  ohiState_e        state;
  logic [CNT_W-1:0] waitCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             windowHit;

  assign windowHit = frmEnable & frmMark;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitCnt   <= '0;
      bitIdx    <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (windowHit) begin
            state   <= ST_HOLD;
            waitCnt <= WAIT_LOAD;
          end
        end
        ST_HOLD: begin
          if (waitCnt == '0) begin
            state  <= ST_SEND;
            bitIdx <= TOP_BIT;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        ST_SEND: begin
          if (bitIdx == '0) begin
            state     <= ST_IDLE;
            donePulse <= 1'b1;
          end else begin
            bitIdx <= bitIdx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state != ST_IDLE);
  assign strb.capture = (state == ST_IDLE) & windowHit;
  assign strb.launch  = (state == ST_SEND);
  assign strb.bitSel  = bitIdx;
  assign strb.busy    = busy;

  // R2
  trig_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && frmEnable && frmMark) |=> busy);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(frmEnable && frmMark)) |=> !busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

endmodule

// File: rtl/ohi_datapath.sv
module ohi_datapath
  import ohi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ohiStrobe_t        strb,
  input  logic [DATA_W-1:0] byteIn,
  output logic              serOut,
  output logic              insertReq
);

  logic [DATA_W-1:0] holdReg;

  // The byte is frozen at the trigger edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strb.capture) begin
      holdReg <= byteIn;
    end
  end

  // Launch on the falling edge so the framer samples on the next rising edge.
  always_ff @(negedge clk) begin
    if (!rstN) begin
      serOut    <= 1'b0;
      insertReq <= 1'b0;
    end else begin
      serOut    <= strb.launch & holdReg[strb.bitSel];
      insertReq <= strb.launch;
    end
  end

  // R8
  ser_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !insertReq |-> !serOut);

  // R7
  ins_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    insertReq |-> strb.busy);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |=> $stable(holdReg));

endmodule

// File: rtl/ohi_top.sv
module ohi_top
  import ohi_pkg::*;
#(
  parameter int WAIT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmEnable,
  input  logic              frmMark,
  input  logic [DATA_W-1:0] byteIn,
  output logic              serOut,
  output logic              insertReq,
  output logic              busy,
  output logic              donePulse
);

  ohiStrobe_t strb;

  ohi_ctrl #(
    .WAIT_CYCLES(WAIT_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frmEnable (frmEnable),
    .frmMark   (frmMark),
    .strb      (strb),
    .busy      (busy),
    .donePulse (donePulse)
  );

  ohi_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .byteIn    (byteIn),
    .serOut    (serOut),
    .insertReq (insertReq)
  );

endmodule

// File: tb/ohi_top_tb_top.sv
`timescale 1ns/100ps
module ohi_top_tb_top;

  localparam int W = 64;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frmEnable;
  logic       frmMark;
  logic [7:0] byteIn;
  logic       serOut;
  logic       insertReq;
  logic       busy;
  logic       donePulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  ohi_top #(.WAIT_CYCLES(W)) dut_i (
    .clk(clk), .rstN(rstN), .frmEnable(frmEnable), .frmMark(frmMark),
    .byteIn(byteIn), .serOut(serOut), .insertReq(insertReq),
    .busy(busy), .donePulse(donePulse)
  );

  // Behavioural reference: tick counts rising edges since the trigger, -1 when idle.
  int         tick = -1;
  int         cyc = 0;
  logic       mBusy = 0, mDone = 0, mSer = 0, mIns = 0;
  logic [7:0] mCap = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      tick = -1; mBusy = 0; mDone = 0;
    end else if (tick < 0) begin
      mDone = 0;
      if (frmEnable && frmMark) begin
        tick = 0; mBusy = 1; mCap = byteIn;
      end
    end else begin
      tick++;
      mDone = 0;
      if (tick == W + 8) begin
        tick = -1; mBusy = 0; mDone = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      mSer = 0; mIns = 0;
    end else if (tick >= W && tick <= W + 7) begin
      mIns = 1; mSer = mCap[7 - (tick - W)];
    end else begin
      mIns = 0; mSer = 0;
    end
  end

  task automatic cmpBit(input logic act, input logic exp, input string req, input string name);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, name, cyc, act, exp);
    end
  endtask

  task automatic cmpInt(input int act, input int exp, input string req, input string name);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, name, cyc, act, exp);
    end
  endtask

  // Per-cycle comparison, plus R3 and R6 trackers.
  int         trigCyc = -1;
  logic       prevBusy = 0, prevIns = 0, lastSer = 0;
  logic [7:0] rx = 0;
  int         nb = 0;
  int         doneSeen = 0;

  initial begin
    forever begin
      @(negedge clk); #1;
      cmpBit(serOut, mSer, mIns ? "R4" : "R8", "serOut");
      cmpBit(insertReq, mIns, "R7", "insertReq");
      cmpBit(busy, mBusy, "R9", "busy");
      cmpBit(donePulse, mDone, "R9", "donePulse");
      if (donePulse) doneSeen++;
      if (!rstN) begin
        trigCyc = -1; nb = 0;
      end else begin
        if (busy && !prevBusy) trigCyc = cyc;
        if (insertReq && !prevIns && trigCyc >= 0)
          cmpInt(cyc - trigCyc, W, "R3", "wait length");
        if (insertReq) begin
          rx = {rx[6:0], serOut}; nb++;
        end
        if (!insertReq && prevIns) begin
          cmpInt(nb, 8, "R4", "bit count");
          cmpInt(int'(rx), int'(mCap), "R6", "received byte");
          nb = 0;
        end
      end
      prevBusy = busy; prevIns = insertReq; lastSer = serOut;
      @(posedge clk); #0.5;
      cmpBit(serOut, lastSer, "R5", "serOut across rising edge");
    end
  end

  task automatic drive(input logic e, input logic f, input logic [7:0] b);
    @(posedge clk); #1;
    frmEnable = e; frmMark = f; byteIn = b;
  endtask

  task automatic idleFor(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, byteIn);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete (R1..R10 unverified)");
    report();
  end

  initial begin
    int d0;
    rstN = 0; frmEnable = 0; frmMark = 0; byteIn = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    cmpBit(serOut, 0, "R1", "serOut in reset");
    cmpBit(insertReq, 0, "R1", "insertReq in reset");
    cmpBit(busy, 0, "R1", "busy in reset");
    cmpBit(donePulse, 0, "R1", "donePulse in reset");
    @(posedge clk); #1; rstN = 1;

    // R2: only one window signal high at a time
    for (int i = 0; i < 12; i++) drive(i[0], ~i[0], 8'hC3);
    for (int i = 0; i < 4; i++) drive(1, 0, 8'h11);
    @(negedge clk); #1;
    cmpBit(busy, 0, "R2", "busy after single-signal windows");

    // R6/R10: trigger, change byte while waiting, window while busy ignored
    drive(1, 1, 8'hA5);
    drive(0, 0, 8'h3C);
    idleFor(20);
    for (int i = 0; i < 10; i++) drive(1, 1, 8'hFF);
    drive(0, 0, 8'h00);
    idleFor(W + 10);
    cmpBit(busy, 0, "R10", "idle after transfer");

    // R10: window held high continuously, back-to-back transfers
    d0 = doneSeen;
    for (int i = 0; i < 3 * (W + 9) + 2; i++) drive(1, 1, 8'(i * 37 + 128));
    drive(0, 0, 8'h00);
    idleFor(W + 12);
    cmpInt(doneSeen - d0, 4, "R10", "done pulses with window held high");

    // Boundary bytes
    drive(1, 1, 8'h00); drive(0, 0, 8'hFF); idleFor(W + 12);
    drive(1, 1, 8'hFF); drive(0, 0, 8'h00); idleFor(W + 12);
    drive(1, 1, 8'h01); drive(0, 0, 8'h80); idleFor(W + 12);

    // R1: reset in the middle of shifting
    drive(1, 1, 8'h5A); drive(0, 0, 8'h5A);
    idleFor(W + 3);
    @(posedge clk); #1; rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    cmpBit(busy, 0, "R1", "busy after mid-transfer reset");
    cmpBit(insertReq, 0, "R1", "insertReq after mid-transfer reset");
    @(posedge clk); #1; rstN = 1;

    // R10: restart after reset
    drive(1, 1, 8'h96); drive(0, 0, 8'h00);
    idleFor(W + 12);
    report();
  end

endmodule